// File: doc/BRIEF.md
# Pixel Clock Gating Sequencer for DAC Pipeline Reset

This block, clocked by the pixel clock, produces the clock pattern a downstream video DAC needs to clear its internal pipeline. A one-cycle trigger, derived upstream from a rising edge of the frequency-select strobe, starts the sequence. A fixed number of pixel clock periods later, the block drops a gate enable, and the outgoing pixel and load clocks stay static. After a fixed number of periods the gate enable returns high and the clocks run again. The gate enable only ever moves on a falling pixel clock edge, so the downstream AND-style gate never emits a shortened pulse.

After a frequency change the synthesizer needs time to settle. A separate pulse restarts a programmable settle counter. A trigger that arrives while the counter runs is remembered and starts the sequence once the counter expires. A trigger that arrives while a sequence runs is dropped. A busy flag covers the whole span, from an accepted or deferred trigger until the clocks have restarted. The settle counter can be left out through a parameter.

Top module: `pix_reset_seq`

## Requirements
- R1: While reset is asserted and after it, until a trigger, `gateEn` is 1 and `busy` is 0.
- R2: A trigger sampled on rising edge T0, with the block idle and no settle wait running, sets `busy` to 1 right after edge T0.
- R3: `gateEn` falls at the falling edge that follows rising edge T0+ACT_DELAY (default 2).
- R4: `gateEn` is low at exactly HOLD_CYCLES (default 4) consecutive rising edges per sequence. It returns high at the falling edge that follows rising edge T0+ACT_DELAY+HOLD_CYCLES.
- R5: `gateEn` changes only while `clk` is low.
- R6: `busy` returns to 0 right after rising edge T0+ACT_DELAY+HOLD_CYCLES+1, one cycle after the clocks restart.
- R7: A trigger sampled while a sequence is running (`busy` high and the sequence started) is ignored. It produces no second sequence.
- R8: A `freqChange` pulse sampled on edge F starts a settle wait that ends after edge F+SETTLE_CYCLES. A trigger sampled during that wait, or on edge F itself, is deferred, and `busy` goes high at once. The sequence then starts at edge F+SETTLE_CYCLES+1 (its T0).
- R9: Several triggers during one settle wait produce a single sequence.
- R10: A `freqChange` pulse during a deferral restarts the wait, which moves the deferred start later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | One-cycle trigger from the strobe rising edge |
| freqChange | input | 1 | One-cycle pulse when a new frequency was selected |
| gateEn | output | 1 | Clock gate enable, 0 holds pixel and load clocks static |
| busy | output | 1 | High from trigger until the clocks restart |

## Verification
Two events can fall on the same rising edge. The first pair is a trigger and a frequency-change pulse. The second pair is a trigger and the last edge of a settle wait. In the first case the trigger must be deferred. In the second it must start the sequence at once. Directed cases put both inputs on one edge and place a trigger on the exact expiry edge. Random stimulus also produces these collisions. A cycle-numbered timeline in the bench judges every edge, both for busy and for the gate on each rising and falling edge.

// File: rtl/pix_reset_pkg.sv
package pix_reset_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic startSeq;   // load the activation delay
    logic loadHold;   // load the hold length
    logic countDown;  // decrement phase counter
    logic holdReq;    // clocks should be held
  } seqCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic phaseDone;
    logic settling;
  } seqStat_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_HOLD  = 2'd2,
    SEQ_TAIL  = 2'd3
  } seqState_t;

endpackage

// File: rtl/pix_reset_dp.sv
module pix_reset_dp
  import pix_reset_pkg::*;
#(
  parameter int ACT_DELAY     = 2,
  parameter int HOLD_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     freqChange,
  input  seqCtrl_t ctrl,
  output seqStat_t stat,
  output logic     gateEn
);
  localparam int MAXPH = (ACT_DELAY > HOLD_CYCLES) ? ACT_DELAY : HOLD_CYCLES;
  localparam int PW    = $clog2(MAXPH + 1);

  logic [PW-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phaseCnt <= '0;
    else if (ctrl.startSeq)
      phaseCnt <= PW'(ACT_DELAY - 1);
    else if (ctrl.loadHold)
      phaseCnt <= PW'(HOLD_CYCLES - 1);
    else if (ctrl.countDown)
      phaseCnt <= phaseCnt - 1'b1;
  end

  assign stat.phaseDone = (phaseCnt == '0);

  generate
    if (SETTLE_CYCLES > 0) begin : g_settle
      localparam int SW = $clog2(SETTLE_CYCLES + 1);
      logic [SW-1:0] settleCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          settleCnt <= '0;
        else if (freqChange)
          settleCnt <= SW'(SETTLE_CYCLES);
        else if (settleCnt != '0)
          settleCnt <= settleCnt - 1'b1;
      end
      assign stat.settling = (settleCnt != '0);
    end else begin : g_nosettle
      logic unusedFc;
      assign unusedFc      = freqChange;
      assign stat.settling = 1'b0;
    end
  endgenerate

  // gate moves on the falling edge only, while the clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)
      gateEn <= 1'b1;
    else
      gateEn <= ~ctrl.holdReq;
  end

endmodule

// File: rtl/pix_reset_ctrl.sv
module pix_reset_ctrl
  import pix_reset_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     trig,
  input  logic     freqChange,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     busy
);
  seqState_t state, stateNext;
  logic      pending;
  logic      startOk;

  assign startOk = (state == SEQ_IDLE) && !stat.settling && !freqChange
                   && (trig || pending);

  always_comb begin
    ctrl         = '0;
    ctrl.holdReq = (state == SEQ_HOLD);
    stateNext    = state;
    unique case (state)
      SEQ_IDLE: begin
        if (startOk) begin
          ctrl.startSeq = 1'b1;
          stateNext     = SEQ_DELAY;
        end
      end
      SEQ_DELAY: begin
        if (stat.phaseDone) begin
          ctrl.loadHold = 1'b1;
          stateNext     = SEQ_HOLD;
        end else begin
          ctrl.countDown = 1'b1;
        end
      end
      SEQ_HOLD: begin
        if (stat.phaseDone) stateNext = SEQ_TAIL;
        else ctrl.countDown = 1'b1;
      end
      SEQ_TAIL: stateNext = SEQ_IDLE;
      default:  stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      pending <= 1'b0;
    end else begin
      state <= stateNext;
      if (startOk)
        pending <= 1'b0;
      else if (state == SEQ_IDLE && trig)
        pending <= 1'b1;
    end
  end

  assign busy = pending || (state != SEQ_IDLE);

endmodule

// File: rtl/pix_reset_seq.sv
module pix_reset_seq
  import pix_reset_pkg::*;
#(
  parameter int ACT_DELAY     = 2,
  parameter int HOLD_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic trig,
  input  logic freqChange,
  output logic gateEn,
  output logic busy
);
  seqCtrl_t ctrl;
  seqStat_t stat;

  pix_reset_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .trig       (trig),
    .freqChange (freqChange),
    .stat       (stat),
    .ctrl       (ctrl),
    .busy       (busy)
  );

  pix_reset_dp #(
    .ACT_DELAY     (ACT_DELAY),
    .HOLD_CYCLES   (HOLD_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .freqChange (freqChange),
    .ctrl       (ctrl),
    .stat       (stat),
    .gateEn     (gateEn)
  );

endmodule

// File: rtl/pix_reset_seq_chk.sv
module pix_reset_seq_chk #(
  parameter int HOLD_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic gateEn,
  input logic busy
);
  int lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       lowRun <= 0;
    else if (!gateEn) lowRun <= lowRun + 1;
    else             lowRun <= 0;
  end

  always @(gateEn) begin
    if (rstN) begin
      AST_GATE_CLK_LOW: assert (clk == 1'b0) else $error("gate moved with clk high"); // R5
    end
  end

  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateEn) |-> (lowRun == HOLD_CYCLES)); // R4

  AST_HOLD_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |-> busy); // R2

  AST_DELAY_BEFORE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateEn) |-> $past(busy, 2)); // R3

  AST_BUSY_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (gateEn && $past(gateEn))); // R6

endmodule

bind pix_reset_seq pix_reset_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .gateEn (gateEn),
  .busy   (busy)
);

// File: tb/test_pix_reset_seq.sv
`timescale 1ns/1ps
module test_pix_reset_seq;
  localparam int ACT    = 2;
  localparam int HOLD   = 4;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 1'b0;
  logic freqChange = 1'b0;
  logic gateEn, busy;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference timeline
  int cyc = 0;
  int seqStart = -1;
  int lastF = -1000000;
  bit pendM = 1'b0;
  int gateFalls = 0;
  int lowSamples = 0;

  always #4 clk = ~clk;

  pix_reset_seq #(
    .ACT_DELAY(ACT), .HOLD_CYCLES(HOLD), .SETTLE_CYCLES(SETTLE)
  ) i_pix_reset_seq (
    .clk(clk), .rstN(rstN), .trig(trig), .freqChange(freqChange),
    .gateEn(gateEn), .busy(busy)
  );

  function automatic bit holdAt(int c);
    return seqStart >= 0 && c >= seqStart + ACT && c <= seqStart + ACT + HOLD - 1;
  endfunction

  function automatic bit seqActiveAt(int c);
    return seqStart >= 0 && c >= seqStart && c <= seqStart + ACT + HOLD;
  endfunction

  function automatic bit settlingBefore(int c);
    return (c - 1) < lastF + SETTLE;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic modelStep(bit t, bit f);
    bit idle;
    idle = !seqActiveAt(cyc - 1);
    if (idle && !settlingBefore(cyc) && !f && (t || pendM)) begin
      seqStart = cyc;
      pendM = 1'b0;
    end else if (idle && t) begin
      pendM = 1'b1;
    end
    if (f) lastF = cyc;
  endtask

  // one pixel clock cycle with the given inputs
  task automatic step(bit t, bit f);
    trig = t;
    freqChange = f;
    @(posedge clk);
    cyc++;
    modelStep(t, f);
    #1;
    trig = 1'b0;
    freqChange = 1'b0;
    if (!gateEn) lowSamples++;
    check("R2/R6/R8 busy", busy, int'(pendM || seqActiveAt(cyc)));
    check("R3/R4 gate at rise", gateEn, int'(!holdAt(cyc - 1)));
    @(negedge clk);
    #1;
    check("R3/R4 gate at fall", gateEn, int'(!holdAt(cyc)));
  endtask

  task automatic idleCycles(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  always @(negedge gateEn) if (rstN) gateFalls++;

  always @(gateEn) begin
    if (rstN) begin
      checks++;
      if (clk) begin
        fails++;
        $display("FAIL R5: gate changed with clk=%0d expected 0", clk);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int f0, l0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 gate in reset", gateEn, 1);
    check("R1 busy in reset", busy, 0);
    rstN = 1'b1;
    idleCycles(3);
    check("R1 gate after reset", gateEn, 1);

    // R2/R3/R4/R6: single sequence
    f0 = gateFalls; l0 = lowSamples;
    step(1'b1, 1'b0);
    check("R2 busy after trigger", busy, 1);
    idleCycles(ACT + HOLD + 3);
    check("R4 low samples", lowSamples - l0, HOLD);
    check("R6 busy cleared", busy, 0);
    check("R3 one gate drop", gateFalls - f0, 1);

    // R7: trigger while running
    f0 = gateFalls;
    step(1'b1, 1'b0);
    idleCycles(2);
    step(1'b1, 1'b0);
    idleCycles(ACT + HOLD + 4);
    check("R7 retrigger ignored", gateFalls - f0, 1);

    // R8: trigger together with frequency change
    f0 = gateFalls;
    step(1'b1, 1'b1);
    idleCycles(SETTLE - 1);
    check("R8 deferred, busy", busy, 1);
    check("R8 deferred, no drop", gateFalls - f0, 0);
    idleCycles(ACT + HOLD + 4);
    check("R8 deferred sequence ran", gateFalls - f0, 1);

    // R9: several triggers during a wait
    f0 = gateFalls;
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    idleCycles(3);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    idleCycles(SETTLE + ACT + HOLD + 4);
    check("R9 single sequence", gateFalls - f0, 1);

    // R10: wait restarted during deferral
    f0 = gateFalls;
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    idleCycles(SETTLE - 5);
    step(1'b0, 1'b1);
    idleCycles(SETTLE - 2);
    check("R10 still deferred", gateFalls - f0, 0);
    check("R10 busy held", busy, 1);
    idleCycles(ACT + HOLD + 4);
    check("R10 sequence after restart", gateFalls - f0, 1);

    // R8: trigger on the expiry edge starts at once
    step(1'b0, 1'b1);
    idleCycles(SETTLE);
    f0 = gateFalls;
    step(1'b1, 1'b0);
    idleCycles(ACT);
    check("R8 expiry-edge start", gateFalls - f0, 1);
    idleCycles(HOLD + 3);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit t, f;
      t = ($urandom_range(0, 7) == 0);
      f = ($urandom_range(0, 149) == 0);
      step(t, f);
    end
    idleCycles(SETTLE + ACT + HOLD + 4);
    check("R6 idle at end", busy, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule